// File: doc/BRIEF.md
# Four-Zone Logical-to-Physical Address Mapper

This block sits between an 8-bit CPU with a 16-bit address bus and a 1 MiB system address space. It splits the 64 KiB logical space into four consecutive zones on 4 KiB page boundaries: a low common zone, two relocatable windows, and a high common zone. The low common zone always lands in physical segment 0. The high common zone always lands in the top physical segment, which holds ROM at the top of the CPU's view. Each relocatable window starts at a programmable 4 KiB physical frame. Translation is combinational from the CPU address, so the physical address is valid in the same cycle as the logical one.

Software programs the three zone boundaries and the two window frame indices through four byte-wide control registers at the very bottom of logical memory. These registers are decoded ahead of any zone mapping, so software can always reach them whatever the current layout is. Any access to them raises a select flag so that the memory behind does not respond. A register write takes effect at the clock edge on which the write strobe is sampled.

Top module: `addr_zone_mapper`

## Requirements
- R1: The low 12 bits of `phys_addr` always equal `cpu_addr[11:0]`.
- R2: A logical page (`cpu_addr[15:12]`) below all three boundaries is in the low common zone and maps to `phys_addr = {4'h0, cpu_addr}`.
- R3: A logical page at or above the high-common boundary maps to `phys_addr = {4'hF, cpu_addr}`, whatever the other boundaries are.
- R4: A page that is at or above the window-A boundary and below both the window-B boundary and the high-common boundary maps to frame `phys_addr[19:12] = baseA + (page - startA)`.
- R5: A page that is at or above the window-B boundary and below the high-common boundary maps to frame `phys_addr[19:12] = baseB + (page - startB)`.
- R6: The frame sum in R4 and R5 wraps modulo 256. For example, base 8'hFF with a page offset of 2 gives frame 8'h01.
- R7: When boundaries are out of order, zones are resolved in the priority high common, window B, window A, low common. A zone whose start is at or above a higher-priority zone's start is empty.
- R8: Register layout: address 0x0000 holds startA in bits [3:0] and startB in bits [7:4]. Address 0x0001 holds the high-common boundary in bits [3:0], and bits [7:4] read as 0. Address 0x0002 holds baseA and 0x0003 holds baseB. `reg_rdata` returns the stored value of the addressed register.
- R9: `reg_sel` is 1 exactly when `cpu_addr` is in 0x0000–0x0003, under any mapping. It is 0 from 0x0004 upward.
- R10: After reset, all three boundaries are 8 and both bases are 0. Logical 0x0000–0x7FFF then maps to physical 0x00000–0x07FFF, and 0x8000–0xFFFF maps to 0xF8000–0xFFFFF.
- R11: A write with `cpu_we`=1 to a register address changes the mapping from the next cycle. With `cpu_we`=0, or when the address is 0x0004 or higher, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU logical address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe, sampled on the rising edge |
| phys_addr | output | 20 | Translated physical address |
| reg_sel | output | 1 | Current access targets a mapper register |
| reg_rdata | output | 8 | Read value of the addressed mapper register |

## Verification
The bench builds the mapper with its default parameters: a 16-bit logical address, a 20-bit physical address, 4 KiB pages and 8-bit frame indices. With these values all 16 logical pages and all 256 physical frames are reachable. Random boundary values therefore cover ordered, coinciding and inverted boundary sets. Random bases near 0xFF exercise the modulo-256 wrap of the frame sum.

// File: rtl/azm_pkg.sv
package azm_pkg;
  localparam int AZM_LA_W  = 16;
  localparam int AZM_PA_W  = 20;
  localparam int AZM_PG_W  = 4;
  localparam int AZM_FR_W  = 8;
  localparam int AZM_DW    = 8;

  typedef enum logic [1:0] {
    ZN_LOWC  = 2'd0,
    ZN_WINA  = 2'd1,
    ZN_WINB  = 2'd2,
    ZN_HIGHC = 2'd3
  } zone_e;

  // Priority resolution: high common, then window B, then window A.
  function automatic zone_e zone_of(
    input logic [AZM_PG_W-1:0] page,
    input logic [AZM_PG_W-1:0] start_a,
    input logic [AZM_PG_W-1:0] start_b,
    input logic [AZM_PG_W-1:0] start_hc
  );
    if (page >= start_hc)      return ZN_HIGHC;
    else if (page >= start_b)  return ZN_WINB;
    else if (page >= start_a)  return ZN_WINA;
    else                       return ZN_LOWC;
  endfunction

  // Frame index of a window page, modulo the frame-index width.
  function automatic logic [AZM_FR_W-1:0] win_frame(
    input logic [AZM_FR_W-1:0] base,
    input logic [AZM_PG_W-1:0] page,
    input logic [AZM_PG_W-1:0] start
  );
    logic [AZM_FR_W-1:0] offs;
    offs = AZM_FR_W'(page) - AZM_FR_W'(start);
    return base + offs;
  endfunction
endpackage

// File: rtl/azm_regfile.sv
module azm_regfile
  import azm_pkg::*;
#(
  parameter int LA_W    = AZM_LA_W,
  parameter int PG_W    = AZM_PG_W,
  parameter int FR_W    = AZM_FR_W,
  parameter int DW      = AZM_DW,
  parameter int RST_BND = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LA_W-1:0] addr,
  input  logic [DW-1:0]   wdata,
  input  logic            we,
  output logic [PG_W-1:0] start_a,
  output logic [PG_W-1:0] start_b,
  output logic [PG_W-1:0] start_hc,
  output logic [FR_W-1:0] base_a,
  output logic [FR_W-1:0] base_b,
  output logic            hit,
  output logic            wr_fire,
  output logic [DW-1:0]   rdata
);
  localparam int REG_CNT = 4;
  localparam int REG_AW  = $clog2(REG_CNT);

  logic [REG_AW-1:0] idx;

  assign idx     = addr[REG_AW-1:0];
  assign hit     = (addr[LA_W-1:REG_AW] == '0);
  assign wr_fire = we & hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_a  <= PG_W'(RST_BND);
      start_b  <= PG_W'(RST_BND);
      start_hc <= PG_W'(RST_BND);
      base_a   <= '0;
      base_b   <= '0;
    end else if (wr_fire) begin
      case (idx)
        2'd0: begin
          start_a <= wdata[PG_W-1:0];
          start_b <= wdata[2*PG_W-1:PG_W];
        end
        2'd1:    start_hc <= wdata[PG_W-1:0];
        2'd2:    base_a   <= wdata[FR_W-1:0];
        default: base_b   <= wdata[FR_W-1:0];
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (idx)
      2'd0:    rdata = DW'({start_b, start_a});
      2'd1:    rdata = DW'(start_hc);
      2'd2:    rdata = DW'(base_a);
      default: rdata = DW'(base_b);
    endcase
  end
endmodule

// File: rtl/azm_zone_sel.sv
module azm_zone_sel
  import azm_pkg::*;
#(
  parameter int PG_W = AZM_PG_W
) (
  input  logic [PG_W-1:0] page,
  input  logic [PG_W-1:0] start_a,
  input  logic [PG_W-1:0] start_b,
  input  logic [PG_W-1:0] start_hc,
  output zone_e           zone
);
  assign zone = zone_of(page, start_a, start_b, start_hc);
endmodule

// File: rtl/azm_xlate.sv
module azm_xlate
  import azm_pkg::*;
#(
  parameter int LA_W = AZM_LA_W,
  parameter int PA_W = AZM_PA_W,
  parameter int PG_W = AZM_PG_W,
  parameter int FR_W = AZM_FR_W
) (
  input  logic [LA_W-1:0] addr,
  input  zone_e           zone,
  input  logic [PG_W-1:0] start_a,
  input  logic [PG_W-1:0] start_b,
  input  logic [FR_W-1:0] base_a,
  input  logic [FR_W-1:0] base_b,
  output logic [PA_W-1:0] phys
);
  localparam int OFF_W  = LA_W - PG_W;
  localparam int SEG_W  = PA_W - LA_W;
  localparam int NWIN   = 2;

  logic [PG_W-1:0] page;
  logic [PG_W-1:0] win_start [NWIN];
  logic [FR_W-1:0] win_base  [NWIN];
  logic [FR_W-1:0] win_fr    [NWIN];

  assign page         = addr[LA_W-1:OFF_W];
  assign win_start[0] = start_a;
  assign win_start[1] = start_b;
  assign win_base[0]  = base_a;
  assign win_base[1]  = base_b;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    assign win_fr[w] = win_frame(win_base[w], page, win_start[w]);
  end

  always_comb begin
    case (zone)
      ZN_LOWC:  phys = {{SEG_W{1'b0}}, addr};
      ZN_HIGHC: phys = {{SEG_W{1'b1}}, addr};
      ZN_WINA:  phys = {win_fr[0], addr[OFF_W-1:0]};
      default:  phys = {win_fr[1], addr[OFF_W-1:0]};
    endcase
  end
endmodule

// File: rtl/addr_zone_mapper.sv
module addr_zone_mapper
  import azm_pkg::*;
#(
  parameter int LA_W    = AZM_LA_W,
  parameter int PA_W    = AZM_PA_W,
  parameter int PG_W    = AZM_PG_W,
  parameter int FR_W    = AZM_FR_W,
  parameter int DW      = AZM_DW,
  parameter int RST_BND = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [15:0]     cpu_addr,
  input  logic [7:0]      cpu_wdata,
  input  logic            cpu_we,
  output logic [19:0]     phys_addr,
  output logic            reg_sel,
  output logic [7:0]      reg_rdata
);
  localparam int OFF_W = LA_W - PG_W;

  logic [PG_W-1:0] start_a, start_b, start_hc;
  logic [FR_W-1:0] base_a, base_b;
  logic [PG_W-1:0] page;
  logic            wr_fire;
  zone_e           zone;

  assign page = cpu_addr[LA_W-1:OFF_W];

  azm_regfile #(
    .LA_W(LA_W), .PG_W(PG_W), .FR_W(FR_W), .DW(DW), .RST_BND(RST_BND)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(cpu_addr), .wdata(cpu_wdata), .we(cpu_we),
    .start_a(start_a), .start_b(start_b), .start_hc(start_hc),
    .base_a(base_a), .base_b(base_b),
    .hit(reg_sel), .wr_fire(wr_fire), .rdata(reg_rdata)
  );

  azm_zone_sel #(.PG_W(PG_W)) u_zone (
    .page(page), .start_a(start_a), .start_b(start_b), .start_hc(start_hc),
    .zone(zone)
  );

  azm_xlate #(
    .LA_W(LA_W), .PA_W(PA_W), .PG_W(PG_W), .FR_W(FR_W)
  ) u_xlate (
    .addr(cpu_addr), .zone(zone), .start_a(start_a), .start_b(start_b),
    .base_a(base_a), .base_b(base_b), .phys(phys_addr)
  );
endmodule

// File: rtl/azm_checker.sv
module azm_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic [7:0]  cpu_wdata,
  input logic        cpu_we,
  input logic [19:0] phys_addr,
  input logic        reg_sel,
  input logic [3:0]  start_a,
  input logic [3:0]  start_b,
  input logic [3:0]  start_hc,
  input logic [7:0]  base_a,
  input logic [7:0]  base_b
);
  logic [3:0] pg;
  logic [7:0] exp_fa, exp_fb;
  assign pg     = cpu_addr[15:12];
  assign exp_fa = base_a + ({4'h0, pg} - {4'h0, start_a});
  assign exp_fb = base_b + ({4'h0, pg} - {4'h0, start_b});

  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr[11:0] == cpu_addr[11:0]); // R1
  AST_LOWC_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (pg < start_a && pg < start_b && pg < start_hc) |-> phys_addr == {4'h0, cpu_addr}); // R2
  AST_HIGHC_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (pg >= start_hc) |-> phys_addr == {4'hF, cpu_addr}); // R3
  AST_WINA_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (pg >= start_a && pg < start_b && pg < start_hc) |-> phys_addr[19:12] == exp_fa); // R4
  AST_WINB_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (pg >= start_b && pg < start_hc) |-> phys_addr[19:12] == exp_fb); // R5
  AST_REG_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel == (cpu_addr < 16'd4)); // R9
  AST_BASEA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_addr == 16'd2) |=> base_a == $past(cpu_wdata)); // R11
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_we && cpu_addr < 16'd4) |=> $stable({start_a, start_b, start_hc, base_a, base_b})); // R11
endmodule

bind addr_zone_mapper azm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
  .cpu_we(cpu_we), .phys_addr(phys_addr), .reg_sel(reg_sel),
  .start_a(start_a), .start_b(start_b), .start_hc(start_hc),
  .base_a(base_a), .base_b(base_b)
);

// File: tb/addr_zone_mapper_test.sv
module addr_zone_mapper_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_we = 1'b0;
  logic [19:0] phys_addr;
  logic        reg_sel;
  logic [7:0]  reg_rdata;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // bench shadow of the programmed state
  logic [3:0] m_sa = 4'd8, m_sb = 4'd8, m_shc = 4'd8;
  logic [7:0] m_ba = 8'd0, m_bb = 8'd0;

  always #5 clk = ~clk;

  addr_zone_mapper uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .phys_addr(phys_addr), .reg_sel(reg_sel), .reg_rdata(reg_rdata)
  );

  function automatic logic [3:0] min2(input logic [3:0] a, input logic [3:0] b);
    return (a < b) ? a : b;
  endfunction

  // zones resolved by their effective upper ends
  function automatic logic [19:0] model_phys(input logic [15:0] a);
    logic [3:0] p;
    int fr;
    p = a[15:12];
    if (p < min2(m_sa, min2(m_sb, m_shc)))
      return {4'h0, a};
    else if (p < min2(m_sb, m_shc)) begin
      fr = (int'(m_ba) + int'(p) - int'(m_sa)) % 256;
      return {fr[7:0], a[11:0]};
    end else if (p < m_shc) begin
      fr = (int'(m_bb) + int'(p) - int'(m_sb)) % 256;
      return {fr[7:0], a[11:0]};
    end
    return {4'hF, a};
  endfunction

  function automatic logic [7:0] model_rd(input logic [1:0] i);
    case (i)
      2'd0: return {m_sb, m_sa};
      2'd1: return {4'h0, m_shc};
      2'd2: return m_ba;
      default: return m_bb;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic probe(input logic [15:0] a, input string req);
    logic [19:0] e;
    @(negedge clk);
    cpu_addr = a;
    #1;
    e = model_phys(a);
    check(phys_addr == e, req, int'(phys_addr), int'(e));
    check(reg_sel == (a < 16'd4), "R9", int'(reg_sel), int'(a < 16'd4));
  endtask

  task automatic readback(input logic [1:0] i, input string req);
    @(negedge clk);
    cpu_addr = {14'd0, i};
    #1;
    check(reg_rdata == model_rd(i), req, int'(reg_rdata), int'(model_rd(i)));
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0;
    if (a < 16'd4) begin
      case (a[1:0])
        2'd0: begin m_sa = d[3:0]; m_sb = d[7:4]; end
        2'd1: m_shc = d[3:0];
        2'd2: m_ba = d;
        default: m_bb = d;
      endcase
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    readback(2'd0, "R10"); readback(2'd1, "R10");
    readback(2'd2, "R10"); readback(2'd3, "R10");
    probe(16'h7FFF, "R10"); probe(16'h8000, "R10");
    probe(16'h0004, "R9");

    // R2 / R4 / R5 / R3 ordered layout
    wr(16'h0000, 8'h52); wr(16'h0001, 8'h0C); wr(16'h0002, 8'h40); wr(16'h0003, 8'h90);
    probe(16'h1ABC, "R2"); probe(16'h2123, "R4"); probe(16'h4FFF, "R4");
    probe(16'h5000, "R5"); probe(16'hBEEF, "R5"); probe(16'hC001, "R3");
    check(phys_addr[11:0] == 12'h001, "R1", int'(phys_addr[11:0]), 1);
    readback(2'd0, "R8"); readback(2'd1, "R8");

    // R6 wrap
    wr(16'h0002, 8'hFF);
    @(negedge clk); cpu_addr = 16'h4123; #1;
    check(phys_addr == 20'h01123, "R6", int'(phys_addr), 32'h01123);

    // R7 inverted boundaries: startA=9, startB=3, high=6
    wr(16'h0000, 8'h39); wr(16'h0001, 8'h06);
    probe(16'h2000, "R7"); probe(16'h3456, "R7"); probe(16'h9000, "R7"); probe(16'h6000, "R7");

    // R9 registers reachable with high common covering everything
    wr(16'h0001, 8'h00);
    probe(16'h0001, "R9"); probe(16'h0003, "R9");
    readback(2'd1, "R8");

    // R11 no write when strobe low or outside the register window
    @(negedge clk); cpu_addr = 16'h0002; cpu_wdata = 8'h77; cpu_we = 1'b0;
    @(negedge clk);
    readback(2'd2, "R11");
    wr(16'h0006, 8'h11);
    readback(2'd2, "R11"); readback(2'd3, "R11");
    wr(16'h0003, 8'h3C);
    readback(2'd3, "R11");

    // randomized mix
    for (int it = 0; it < 400; it++) begin
      if (($urandom % 3) == 0)
        wr(16'($urandom % 5), 8'($urandom));
      probe(16'($urandom), "R4/R5");
      if (($urandom % 4) == 0)
        readback(2'($urandom), "R8");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule